// File: doc/BRIEF.md
# Indirect-Indexed Codec Register File

This block is the control register file of an audio codec. It sits behind a 64-byte bus window made of sixteen word-spaced 32-bit direct registers. The word index is the byte address without its two low bits. Most direct registers are plain 32-bit storage. Four of them have a special role:
- a pointer register, whose low five bits pick one of thirty-two 8-bit indirect registers;
- a data port, through which the picked indirect register is read and written;
- a read-only register;
- a control register, which can start a software reset.

Several indirect registers have their own access rules:
- one always reads as zero;
- two ignore writes;
- one merges a single writable bit with a fixed identification code.

Each bus cycle is classified combinationally into one of five targets: `TGT_PLAIN` (ordinary storage), `TGT_PTR` (pointer), `TGT_PORT` (data port), `TGT_RO` (read-only word) and `TGT_CTRL` (control word). The class follows the word index, and it selects the write path and the read source. Read data is captured in a register on the clock edge that samples the read strobe. The interrupt output is held low.

Top module: `codec_regfile`

## Requirements
- R1: The word index is `addr[5:2]`. A write to any of the words 0, 3 and 5 through 15 stores all 32 bits, and a later read of that word returns them.
- R2: After the reset input is asserted, every direct word reads 0x00000000. Every indirect register reads 0x00, except indirect 12, which reads 0x8A, and indirect 25, which reads 0xA0.
- R3: Bits [4:0] of word 0 select the indirect register. A read of word 1 returns the selected indirect register, zero-extended to 32 bits. A write to word 1 stores `wdata[7:0]` into the selected indirect register, subject to R4, R5 and R6.
- R4: A read of indirect 3 through word 1 always returns zero.
- R5: Writes to indirect 11 and indirect 25 leave their contents unchanged.
- R6: A write of value w to indirect 12 stores `(w & 0x40) | 0x8A`.
- R7: Word 2 ignores writes and always reads zero.
- R8: A write to word 4 with `wdata[0]` = 1 restores every register to its R2 value on the same clock edge. Word 4 then holds `wdata & 0x7F`.
- R9: A write to word 4 with `wdata[0]` = 0 stores `wdata & 0x7F` and leaves every other register unchanged.
- R10: `rdata` takes the read value on the rising edge at which `rd_en` is sampled high. It keeps that value on every edge at which `rd_en` is low.
- R11: `irq` is 0 at all times.
- R12: When a read and a write hit the same cycle, `rdata` returns the value that was held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 6 | Byte address within the window |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, held low |

## Verification
The assertions check several invariants on every cycle:
- the fixed indirect codes, and the constant part of indirect 12;
- the 7-bit limit on the control word;
- the low interrupt line;
- the zero reads of word 2 and of indirect 3;
- `rdata` holding when no read is issued;
- the pointer being cleared after a software reset.

Only the bench scenarios can show that stored data comes back intact at the right word or indirect index. The same applies to the ordering of a read against a write in the same cycle, and to a software reset wiping earlier writes while a control write without bit 0 preserves them.

// File: rtl/codec_reg_pkg.sv
package codec_reg_pkg;

    // Roles of the direct words
    localparam int DIR_PTR   = 0;
    localparam int DIR_PORT  = 1;
    localparam int DIR_RO    = 2;
    localparam int DIR_CTRL  = 4;
    localparam int CTRL_KEEP = 7;   // bits retained by the control word

    // Indirect registers with access rules
    localparam int IND_WO     = 3;
    localparam int IND_RO_A   = 11;
    localparam int IND_MASKED = 12;
    localparam int IND_RO_B   = 25;

    localparam logic [7:0] CODEC_ID  = 8'h8A;
    localparam logic [7:0] CHIP_ID   = 8'hA0;
    localparam logic [7:0] KEEP_MASK = 8'h40;

    typedef enum logic [2:0] {
        TGT_PLAIN,
        TGT_PTR,
        TGT_PORT,
        TGT_RO,
        TGT_CTRL
    } tgt_e;

    function automatic logic [7:0] ind_init(input int idx);
        if (idx == IND_MASKED) return CODEC_ID;
        if (idx == IND_RO_B)   return CHIP_ID;
        return 8'h00;
    endfunction

endpackage

// File: rtl/codec_direct_bank.sv
module codec_direct_bank
    import codec_reg_pkg::*;
#(
    parameter int NUM_DIR = 16,
    parameter int DATA_W  = 32,
    localparam int WORD_W = $clog2(NUM_DIR)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           soft_rst,
    input  logic                           we,
    input  logic [WORD_W-1:0]              word,
    input  logic [DATA_W-1:0]              wdata,
    output logic [NUM_DIR-1:0][DATA_W-1:0] dir_q
);

    localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((1 << CTRL_KEEP) - 1);

    for (genvar i = 0; i < NUM_DIR; i++) begin : g_word
        if (i == DIR_PORT || i == DIR_RO) begin : g_none
            // No storage behind the data port or the read-only word
            assign dir_q[i] = '0;
        end else if (i == DIR_CTRL) begin : g_ctrl
            always_ff @(posedge clk) begin
                if (!rst_n)
                    dir_q[i] <= '0;
                else if (soft_rst || (we && word == WORD_W'(i)))
                    dir_q[i] <= wdata & CTRL_MASK;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst)
                    dir_q[i] <= '0;
                else if (we && word == WORD_W'(i))
                    dir_q[i] <= wdata;
            end
        end
    end

endmodule

// File: rtl/codec_indirect_bank.sv
module codec_indirect_bank
    import codec_reg_pkg::*;
#(
    parameter int IND_AW  = 5,
    localparam int NUM_IND = 1 << IND_AW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      soft_rst,
    input  logic                      we,
    input  logic [IND_AW-1:0]         idx,
    input  logic [7:0]                wbyte,
    output logic [NUM_IND-1:0][7:0]   ind_q
);

    for (genvar i = 0; i < NUM_IND; i++) begin : g_ind
        localparam logic [7:0] INIT = ind_init(i);
        if (i == IND_RO_A || i == IND_RO_B) begin : g_fixed
            // Writes never land here, so the reset value is permanent
            assign ind_q[i] = INIT;
        end else begin : g_store
            logic [7:0] next_val;
            if (i == IND_MASKED) begin : g_merge
                assign next_val = (wbyte & KEEP_MASK) | CODEC_ID;
            end else begin : g_raw
                assign next_val = wbyte;
            end
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst)
                    ind_q[i] <= INIT;
                else if (we && idx == IND_AW'(i))
                    ind_q[i] <= next_val;
            end
        end
    end

endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
    import codec_reg_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int IND_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam int WORD_W  = ADDR_W - 2;
    localparam int NUM_DIR = 1 << WORD_W;
    localparam int NUM_IND = 1 << IND_AW;

    localparam logic [WORD_W-1:0] W_PTR  = WORD_W'(DIR_PTR);
    localparam logic [WORD_W-1:0] W_PORT = WORD_W'(DIR_PORT);
    localparam logic [WORD_W-1:0] W_RO   = WORD_W'(DIR_RO);
    localparam logic [WORD_W-1:0] W_CTRL = WORD_W'(DIR_CTRL);

    logic [WORD_W-1:0]              word;
    logic                           unused_lsb;
    tgt_e                           tgt;
    logic                           soft_rst;
    logic                           dir_we;
    logic                           ind_we;
    logic [IND_AW-1:0]              ind_idx;
    logic [DATA_W-1:0]              rd_val;
    logic [NUM_DIR-1:0][DATA_W-1:0] dir_q;
    logic [NUM_IND-1:0][7:0]        ind_q;

    assign word       = addr[ADDR_W-1:2];
    assign unused_lsb = ^addr[1:0];

    // Target classification of the current bus cycle
    always_comb begin
        unique case (word)
            W_PTR:   tgt = TGT_PTR;
            W_PORT:  tgt = TGT_PORT;
            W_RO:    tgt = TGT_RO;
            W_CTRL:  tgt = TGT_CTRL;
            default: tgt = TGT_PLAIN;
        endcase
    end

    // Write-path outputs of the classification
    always_comb begin
        soft_rst = 1'b0;
        dir_we   = 1'b0;
        ind_we   = 1'b0;
        unique case (tgt)
            TGT_PLAIN, TGT_PTR: dir_we = wr_en;
            TGT_CTRL: begin
                dir_we   = wr_en;
                soft_rst = wr_en & wdata[0];
            end
            TGT_PORT: ind_we = wr_en;
            TGT_RO:   ;
            default:  ;
        endcase
    end

    assign ind_idx = dir_q[DIR_PTR][IND_AW-1:0];

    // Read source selection
    always_comb begin
        unique case (tgt)
            TGT_PORT: rd_val = (ind_idx == IND_AW'(IND_WO)) ? '0
                                                            : DATA_W'(ind_q[ind_idx]);
            TGT_RO:   rd_val = '0;
            default:  rd_val = dir_q[word];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_val;
    end

    assign irq = 1'b0;

    codec_direct_bank #(
        .NUM_DIR (NUM_DIR),
        .DATA_W  (DATA_W)
    ) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .we       (dir_we),
        .word     (word),
        .wdata    (wdata),
        .dir_q    (dir_q)
    );

    codec_indirect_bank #(
        .IND_AW (IND_AW)
    ) u_ind (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .we       (ind_we),
        .idx      (ind_idx),
        .wbyte    (wdata[7:0]),
        .ind_q    (ind_q)
    );

endmodule

// File: rtl/codec_regfile_chk.sv
module codec_regfile_chk
    import codec_reg_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int IND_AW = 5,
    localparam int NUM_DIR = 1 << (ADDR_W - 2),
    localparam int NUM_IND = 1 << IND_AW
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [ADDR_W-1:0]              addr,
    input logic [DATA_W-1:0]              wdata,
    input logic                           wr_en,
    input logic                           rd_en,
    input logic [DATA_W-1:0]              rdata,
    input logic                           irq,
    input logic [NUM_DIR-1:0][DATA_W-1:0] dir_q,
    input logic [NUM_IND-1:0][7:0]        ind_q
);

    AST_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        irq == 1'b0); // R11

    AST_CHIP_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        ind_q[IND_RO_B] == CHIP_ID); // R5

    AST_CODEC_ID_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_q[IND_MASKED] & ~KEEP_MASK) == CODEC_ID); // R6

    AST_CTRL_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        dir_q[DIR_CTRL][DATA_W-1:CTRL_KEEP] == '0); // R9

    AST_RO_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[ADDR_W-1:2] == (ADDR_W-2)'(DIR_RO)) |=> rdata == '0); // R7

    AST_WO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[ADDR_W-1:2] == (ADDR_W-2)'(DIR_PORT)
               && dir_q[DIR_PTR][IND_AW-1:0] == IND_AW'(IND_WO)) |=> rdata == '0); // R4

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R10

    AST_SOFT_RST_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[0] && addr[ADDR_W-1:2] == (ADDR_W-2)'(DIR_CTRL))
            |=> dir_q[DIR_PTR] == '0); // R8

endmodule

bind codec_regfile codec_regfile_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IND_AW (IND_AW)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wdata (wdata),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .rdata (rdata),
    .irq   (irq),
    .dir_q (dir_q),
    .ind_q (ind_q)
);

// File: tb/sim_codec_regfile.sv
module sim_codec_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    codec_regfile u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wdata (wdata),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .rdata (rdata),
        .irq   (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input int w, input logic [31:0] d);
        @(negedge clk);
        addr  = 6'(w * 4);
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int w, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr  = 6'(w * 4);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, rdata, exp);
    endtask

    task automatic ind_rd(input int i, input logic [31:0] exp, input string tag);
        wr(0, 32'hFFFF_FFE0 | 32'(i));
        rd(1, exp, tag);
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'h9E37_79B9 * 32'(i + 1);
    endfunction

    function automatic logic [7:0] wbyte(input int i);
        return 8'((i * 29 + 7) & 8'hFF) | 8'h40 * 8'(i % 2);
    endfunction

    function automatic logic [31:0] ind_reset_exp(input int i);
        if (i == 12) return 32'h8A;
        if (i == 25) return 32'hA0;
        return 32'h0;
    endfunction

    function automatic logic [31:0] ind_written_exp(input int i, input logic [7:0] w);
        if (i == 3)              return 32'h0;            // R4
        if (i == 11 || i == 25)  return ind_reset_exp(i); // R5
        if (i == 12)             return 32'((w & 8'h40) | 8'h8A); // R6
        return 32'(w);
    endfunction

    task automatic reset_sweep(input string tag);
        for (int i = 0; i < 16; i++) rd(i, 32'h0, tag);
        for (int i = 0; i < 32; i++) ind_rd(i, ind_reset_exp(i), tag);
    endtask

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R2 rdata after reset", rdata, 32'h0);
        check("R11 irq", {31'h0, irq}, 32'h0);

        reset_sweep("R2 reset values");

        // R1 plain words
        for (int i = 0; i < 16; i++)
            if (i != 1 && i != 2 && i != 4) wr(i, pat(i));
        for (int i = 0; i < 16; i++)
            if (i != 1 && i != 2 && i != 4) rd(i, pat(i), "R1 plain word readback");

        // R7 read-only word
        wr(2, 32'hDEAD_BEEF);
        rd(2, 32'h0, "R7 word 2 ignores write");

        // R9 control word without reset bit
        wr(4, 32'hFFFF_FF7E);
        rd(4, 32'h0000_007E, "R9 control masked");
        rd(5, pat(5), "R9 other word kept");

        // R12 simultaneous read and write
        @(negedge clk);
        addr = 6'(6 * 4); wdata = 32'h1234_5678; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R12 read returns old value", rdata, pat(6));
        rd(6, 32'h1234_5678, "R12 write landed");

        // R10 hold without read strobe
        wr(7, 32'h0BAD_F00D);
        repeat (3) @(negedge clk);
        check("R10 rdata holds", rdata, 32'h1234_5678);

        // R3..R6 indirect sweep through the data port
        for (int i = 0; i < 32; i++) begin
            wr(0, 32'hFFFF_FFE0 | 32'(i));
            wr(1, {24'hC3C3C3, wbyte(i)});
        end
        for (int i = 0; i < 32; i++)
            ind_rd(i, ind_written_exp(i, wbyte(i)), "R3 indirect readback");
        rd(0, 32'hFFFF_FFE0 | 32'd31, "R1 pointer word full width");

        // R8 software reset
        wr(0, 32'h0000_0012);
        wr(4, 32'h0000_0FF1);
        rd(4, 32'h0000_0071, "R8 control keeps masked value");
        rd(0, 32'h0, "R8 pointer cleared");
        rd(5, 32'h0, "R8 plain word cleared");
        for (int i = 0; i < 32; i++) ind_rd(i, ind_reset_exp(i), "R8 indirect restored");
        check("R11 irq", {31'h0, irq}, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule